// File: doc/BRIEF.md
# Floating-Point Reciprocal Exponent Unit

This block produces a coarse reciprocal estimate of an IEEE-754 operand in either single or double precision. It does no arithmetic on the value. The sign passes through unchanged. The exponent field is replaced by its bitwise complement, or by the largest finite exponent when the input exponent is zero. The fraction is cleared. A caller typically uses the result as a scale factor that brings a quotient or reciprocal iteration into a safe range.

A precision select chooses the format for each operation. A valid strobe qualifies the operand, and the result appears on a registered output one clock later. NaN operands bypass the exponent logic. A signaling NaN is quieted and raises an invalid-operation flag. A quiet NaN passes through untouched. When the default-NaN control is set, every NaN is replaced by the canonical default NaN. The invalid flag is sticky and stays set until a clear strobe is given.

Top module: `rcpx_unit`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `op_valid` high. `res_word` then holds the result of that operand, and `res_valid` is low otherwise.
- R2: For every non-NaN operand, the result sign bit equals the operand sign bit. The sign is bit 31 for single precision and bit 63 for double precision.
- R3: For a non-NaN operand with a nonzero exponent field, the result exponent is the bitwise complement of the operand exponent. The exponent is bits 30:23 for single and bits 62:52 for double, so an infinity yields exponent zero.
- R4: For an operand with a zero exponent field (zeros and subnormals), the result exponent has every bit set except its least significant bit: 0xFE for single, 0x7FE for double.
- R5: For every non-NaN operand, the result fraction field is zero. The fraction is bits 22:0 for single and bits 51:0 for double.
- R6: With `fmt_dbl` low, only `op_word[31:0]` is used, bits 63:32 of the operand have no effect, and `res_word[63:32]` is zero. With `fmt_dbl` high, all 64 bits are used.
- R7: A signaling NaN (exponent all ones, fraction nonzero, top fraction bit 0) with `dn_mode` low is returned with its top fraction bit set and all other bits unchanged. It also sets `inv_flag`.
- R8: A quiet NaN (exponent all ones, top fraction bit 1) with `dn_mode` low is returned unchanged and leaves `inv_flag` unchanged.
- R9: With `dn_mode` high, any NaN returns the default NaN: 0x7FC00000 for single, 0x7FF8000000000000 for double. A signaling NaN still sets `inv_flag`.
- R10: `inv_flag` stays set until `flag_clr` is high for a cycle, after which it reads zero. If a signaling NaN is accepted in the same cycle as `flag_clr`, the flag stays set.
- R11: While `rst_n` is low at a clock edge, `res_valid`, `res_word` and `inv_flag` become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operand qualifier |
| fmt_dbl | input | 1 | 1 selects double precision, 0 selects single |
| dn_mode | input | 1 | Replace every NaN result with the default NaN |
| flag_clr | input | 1 | Clears the sticky invalid flag |
| op_word | input | 64 | Operand; single uses bits 31:0 |
| res_valid | output | 1 | Result qualifier, one cycle after op_valid |
| res_word | output | 64 | Result; single in bits 31:0 with upper half zero |
| inv_flag | output | 1 | Sticky invalid-operation flag |

## Verification
The main function is tested in both formats with positive and negative normal values. These show whether the exponent is complemented and the sign kept. Positive and negative zeros and subnormals check the fixed exponent substitution. Infinities separate the all-ones exponent from the NaN path. Signaling and quiet NaNs are applied with and without the default-NaN control, which separates quieting, pass-through and substitution and shows which cases may raise the flag. Single-precision operands with garbage in the upper half, clear strobes alone and clear strobes together with a signaling NaN cover the ignored bits and the flag priority.

// File: rtl/rcpx_pkg.sv
// Package: shared format widths and the precision select encoding for the
// reciprocal exponent unit. Assumes IEEE-754 binary32 / binary64 layouts.
package rcpx_pkg;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;

    typedef enum logic {
        FMT_SINGLE = 1'b0,
        FMT_DOUBLE = 1'b1
    } fmt_e;
endpackage

// File: rtl/rcpx_exp_xform.sv
// Module: exponent field transform. A nonzero exponent is inverted; a zero
// exponent maps to the largest finite exponent (all ones but the LSB).
// Assumes the caller has already routed NaN operands elsewhere.
module rcpx_exp_xform #(
    parameter int EXP_W = 8
) (
    input  logic [EXP_W-1:0] exp_in,
    output logic [EXP_W-1:0] exp_out
);
    localparam logic [EXP_W-1:0] MAX_FINITE = {{(EXP_W-1){1'b1}}, 1'b0};

    // Pick the substitution for zero exponents, complement otherwise.
    always_comb begin
        if (exp_in == '0) begin
            exp_out = MAX_FINITE;
        end else begin
            exp_out = ~exp_in;
        end
    end
endmodule

// File: rtl/rcpx_lane.sv
// Module: one precision lane. Splits the word into fields, classifies NaNs,
// and builds either the reciprocal exponent result or the NaN result.
// Assumes a standard IEEE-754 word layout of sign, exponent, fraction.
module rcpx_lane #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] lane_in,
    input  logic                  dn_mode,
    output logic [EXP_W+FRAC_W:0] lane_out,
    output logic                  lane_snan
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam logic [FRAC_W-1:0] QUIET_BIT = {1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] DEFAULT_NAN = {1'b0, {EXP_W{1'b1}}, QUIET_BIT};

    logic              sgn;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic [EXP_W-1:0]  new_exp;
    logic              is_nan;

    assign sgn  = lane_in[WORD_W-1];
    assign expo = lane_in[WORD_W-2:FRAC_W];
    assign frac = lane_in[FRAC_W-1:0];

    rcpx_exp_xform #(.EXP_W(EXP_W)) u_xform (
        .exp_in  (expo),
        .exp_out (new_exp)
    );

    // Classify the operand as NaN / signaling NaN.
    always_comb begin
        is_nan    = (&expo) && (|frac);
        lane_snan = is_nan && !frac[FRAC_W-1];
    end

    // Build the lane result from the classification.
    always_comb begin
        if (is_nan) begin
            lane_out = dn_mode ? DEFAULT_NAN : (lane_in | {{(WORD_W-FRAC_W){1'b0}}, QUIET_BIT});
        end else begin
            lane_out = {sgn, new_exp, {FRAC_W{1'b0}}};
        end
    end

    // Check lane result fields against the operand fields.
    always_comb begin
        if (!is_nan) begin
            // R2
            sign_keep_chk: assert (lane_out[WORD_W-1] == lane_in[WORD_W-1]);
            // R5
            frac_clear_chk: assert (lane_out[FRAC_W-1:0] == '0);
        end else begin
            // R9
            nan_quiet_chk: assert ((&lane_out[WORD_W-2:FRAC_W]) && lane_out[FRAC_W-1]);
        end
    end
endmodule

// File: rtl/rcpx_sticky.sv
// Module: sticky invalid-operation flag. A set request wins over a clear
// request in the same cycle. Synchronous active-low reset.
module rcpx_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    // Hold, set or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_req) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr_req |=> flag);
    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req && !set_req |=> !flag);
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> flag);
endmodule

// File: rtl/rcpx_unit.sv
// Module: top of the reciprocal exponent unit. Runs both precision lanes on
// the operand, selects one by fmt_dbl, and registers result and valid.
// Assumes single-precision operands sit in the low half of op_word.
module rcpx_unit #(
    parameter int SP_EXP_W  = rcpx_pkg::SP_EXP_W,
    parameter int SP_FRAC_W = rcpx_pkg::SP_FRAC_W,
    parameter int DP_EXP_W  = rcpx_pkg::DP_EXP_W,
    parameter int DP_FRAC_W = rcpx_pkg::DP_FRAC_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             op_valid,
    input  logic                             fmt_dbl,
    input  logic                             dn_mode,
    input  logic                             flag_clr,
    input  logic [DP_EXP_W+DP_FRAC_W:0]      op_word,
    output logic                             res_valid,
    output logic [DP_EXP_W+DP_FRAC_W:0]      res_word,
    output logic                             inv_flag
);
    import rcpx_pkg::*;

    localparam int SP_W = 1 + SP_EXP_W + SP_FRAC_W;
    localparam int DP_W = 1 + DP_EXP_W + DP_FRAC_W;

    logic [SP_W-1:0] sp_out;
    logic [DP_W-1:0] dp_out;
    logic            sp_snan;
    logic            dp_snan;
    logic [DP_W-1:0] sel_res;
    logic            sel_snan;
    fmt_e            fmt;

    assign fmt = fmt_e'(fmt_dbl);

    rcpx_lane #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_lane_sp (
        .lane_in   (op_word[SP_W-1:0]),
        .dn_mode   (dn_mode),
        .lane_out  (sp_out),
        .lane_snan (sp_snan)
    );

    rcpx_lane #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_lane_dp (
        .lane_in   (op_word),
        .dn_mode   (dn_mode),
        .lane_out  (dp_out),
        .lane_snan (dp_snan)
    );

    // Select the lane that matches the requested precision.
    always_comb begin
        if (fmt == FMT_DOUBLE) begin
            sel_res  = dp_out;
            sel_snan = dp_snan;
        end else begin
            sel_res  = {{(DP_W-SP_W){1'b0}}, sp_out};
            sel_snan = sp_snan;
        end
    end

    // Register the result and its qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_word  <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_word <= sel_res;
            end
        end
    end

    rcpx_sticky u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (op_valid && sel_snan),
        .clr_req (flag_clr),
        .flag    (inv_flag)
    );

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);
    // R6
    single_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !fmt_dbl |=> res_word[DP_W-1:SP_W] == '0);
endmodule

// File: tb/rcpx_unit_bench.sv
// Scoreboard bench for rcpx_unit: the driver pushes expected results into a
// queue, the monitor pops and compares them when res_valid is seen.
module rcpx_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        fmt_dbl = 1'b0;
    logic        dn_mode = 1'b0;
    logic        flag_clr = 1'b0;
    logic [63:0] op_word = '0;
    logic        res_valid;
    logic [63:0] res_word;
    logic        inv_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic mflag = 1'b0;

    typedef struct {
        logic [63:0] res;
        logic        flag;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    rcpx_unit u_rcpx_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .fmt_dbl   (fmt_dbl),
        .dn_mode   (dn_mode),
        .flag_clr  (flag_clr),
        .op_word   (op_word),
        .res_valid (res_valid),
        .res_word  (res_word),
        .inv_flag  (inv_flag)
    );

    // Reference model written from the requirements.
    function automatic logic [63:0] model(input logic dbl, input logic [63:0] op,
                                          input logic dn, output logic snan);
        int ew = dbl ? 11 : 8;
        int fw = dbl ? 52 : 23;
        logic [63:0] w    = dbl ? op : {32'h0, op[31:0]};
        logic [63:0] emax = (64'd1 << ew) - 64'd1;
        logic [63:0] e    = (w >> fw) & emax;
        logic [63:0] f    = w & ((64'd1 << fw) - 64'd1);
        logic [63:0] qb   = 64'd1 << (fw - 1);
        logic [63:0] sg   = (w >> (ew + fw)) & 64'd1;
        logic [63:0] ne;
        snan = 1'b0;
        if (e == emax && f != 0) begin
            snan = ((f & qb) == 0);
            return dn ? ((emax << fw) | qb) : (w | qb);
        end
        ne = (e == 0) ? (emax - 64'd1) : (emax - e);
        return (sg << (ew + fw)) | (ne << fw);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Driver: apply one operand and push its expected result.
    task automatic drive(input logic dbl, input logic [63:0] op, input logic dn,
                         input logic clr, input string tag);
        exp_t it;
        logic sn;
        it.res = model(dbl, op, dn, sn);
        mflag = sn ? 1'b1 : (clr ? 1'b0 : mflag);
        it.flag = mflag;
        it.tag = tag;
        sb_q.push_back(it);
        op_valid = 1'b1;
        fmt_dbl  = dbl;
        op_word  = op;
        dn_mode  = dn;
        flag_clr = clr;
        @(negedge clk);
        op_valid = 1'b0;
        flag_clr = 1'b0;
    endtask

    // Pulse flag_clr alone and check the flag reads zero one cycle later.
    task automatic clear_flag();
        flag_clr = 1'b1;
        mflag = 1'b0;
        @(negedge clk);
        flag_clr = 1'b0;
        check(inv_flag == mflag, "R10 clear", {63'b0, inv_flag}, {63'b0, mflag});
    endtask

    // Idle cycle: no result may be reported.
    task automatic idle_check();
        @(negedge clk);
        check(res_valid == 1'b0, "R1 idle", {63'b0, res_valid}, 64'd0);
    endtask

    // Monitor: compare each reported result against the queue head.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R1 unexpected valid", res_word, 64'd0);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                check(res_word == it.res, it.tag, res_word, it.res);
                check(inv_flag == it.flag, {it.tag, " flag"}, {63'b0, inv_flag}, {63'b0, it.flag});
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R11 valid", {63'b0, res_valid}, 64'd0);
        check(res_word == 64'd0, "R11 result", res_word, 64'd0);
        check(inv_flag == 1'b0, "R11 flag", {63'b0, inv_flag}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3: normal values, single precision, back to back
        drive(1'b0, 64'h3F800000, 1'b0, 1'b0, "R3 sp 1.0");
        drive(1'b0, 64'hBF800000, 1'b0, 1'b0, "R2 sp -1.0");
        drive(1'b0, 64'h41200000, 1'b0, 1'b0, "R3 sp 10.0");
        drive(1'b0, 64'h7F800000, 1'b0, 1'b0, "R3 sp +inf");
        drive(1'b0, 64'hFF800000, 1'b0, 1'b0, "R2 sp -inf");
        idle_check();
        // R4 R5: zeros and subnormals
        drive(1'b0, 64'h00000000, 1'b0, 1'b0, "R4 sp +0");
        drive(1'b0, 64'h80000000, 1'b0, 1'b0, "R4 sp -0");
        drive(1'b0, 64'h007FFFFF, 1'b0, 1'b0, "R5 sp subnormal");
        drive(1'b0, 64'h3FFFFFFF, 1'b0, 1'b0, "R5 sp frac ones");
        // R6: upper half ignored in single precision
        drive(1'b0, 64'hDEADBEEF_3F800000, 1'b0, 1'b0, "R6 sp upper garbage");
        drive(1'b0, 64'hFFFFFFFF_00000001, 1'b0, 1'b0, "R6 sp upper ones");
        // double precision
        drive(1'b1, 64'h3FF0000000000000, 1'b0, 1'b0, "R3 dp 1.0");
        drive(1'b1, 64'hC024000000000000, 1'b0, 1'b0, "R2 dp -10.0");
        drive(1'b1, 64'h0000000000000000, 1'b0, 1'b0, "R4 dp +0");
        drive(1'b1, 64'h800FFFFFFFFFFFFF, 1'b0, 1'b0, "R4 dp -subnormal");
        drive(1'b1, 64'h7FF0000000000000, 1'b0, 1'b0, "R3 dp +inf");
        idle_check();
        // R8: quiet NaNs pass unchanged, flag stays clear
        drive(1'b0, 64'hFFC01234, 1'b0, 1'b0, "R8 sp qnan");
        drive(1'b1, 64'h7FF8000000ABCDEF, 1'b0, 1'b0, "R8 dp qnan");
        // R7: signaling NaN quieted and flag set
        drive(1'b0, 64'h7F800001, 1'b0, 1'b0, "R7 sp snan");
        // R10: flag sticky across later quiet and normal ops
        drive(1'b0, 64'h3F800000, 1'b0, 1'b0, "R10 sticky normal");
        drive(1'b1, 64'hFFF8000000000001, 1'b0, 1'b0, "R10 sticky qnan");
        clear_flag();
        drive(1'b1, 64'hFFF0000000000010, 1'b0, 1'b0, "R7 dp snan");
        clear_flag();
        // R9: default NaN mode
        drive(1'b0, 64'hFFC01234, 1'b1, 1'b0, "R9 sp qnan dn");
        drive(1'b1, 64'hFFF8000000000055, 1'b1, 1'b0, "R9 dp qnan dn");
        drive(1'b0, 64'hFFA00000, 1'b1, 1'b0, "R9 sp snan dn");
        clear_flag();
        drive(1'b1, 64'h7FF4000000000000, 1'b1, 1'b0, "R9 dp snan dn");
        // R9: default mode does not affect ordinary values
        drive(1'b1, 64'h3FF0000000000000, 1'b1, 1'b0, "R9 dp normal dn");
        // R10: clear with a simultaneous signaling NaN keeps the flag set
        drive(1'b0, 64'h7F800002, 1'b0, 1'b1, "R10 clr and snan");
        // R10: clear together with a quiet NaN clears the flag
        drive(1'b0, 64'h7FC00000, 1'b0, 1'b1, "R10 clr and qnan");
        idle_check();
        idle_check();
        check(sb_q.size() == 0, "R1 drained", 64'(sb_q.size()), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule